// File: doc/BRIEF.md
# Multiplexed-Address Flash Command Interface

This block is the slave-side control logic of a byte-wide flash device. The device takes its address through an 11-bit port in two halves, a row half and a column half. A row/column select input sorts each half into the right register. The device pins are sampled on a system clock. The output-enable, write-enable and reset pins are decoded into bus reads, bus writes, output disable and reset.

Bus writes never touch the array directly. Each written byte goes to a command state machine. That machine decides what a bus read returns: array bytes, a status byte, or the two identification codes. Byte programs and block erases run in a modelled program/erase controller, whose duration is set by a cycle counter. The array itself is a small behavioural byte store. The state machine turns away every command while an operation is in flight. A reset that arrives during an operation aborts it and leaves the affected bytes holding a fixed poison value.

Top module: `fmx_flash_ctl`

## Requirements
- R1: In each clock with `rst_n` high, `rc_sel`=0 loads `addr_in` as the row half and `rc_sel`=1 loads it as the column half. The byte index is the low `$clog2(DEPTH)` bits of {column, row}. Until both halves have been loaded since reset, reads are not driven and writes are ignored.
- R2: `dq_oe` is 1 exactly when `rst_n`=1, `oe_n`=0, `we_n`=1 and both address halves are loaded. In that case `dq_out` carries the byte chosen by the current mode.
- R3: A write is taken from `dq_in` in the first clock in which `we_n` is seen high after being seen low, provided `oe_n` and `rst_n` are both high in that clock. A write seen with `oe_n` low is dropped. A written byte only ever reaches the command decoder.
- R4: With `oe_n` high, `dq_oe` is 0.
- R5: A clock with `rst_n` low turns the outputs off, sets read-array mode, clears any half-entered command and clears both address halves.
- R6: Writing 0xFF selects read-array mode, in which reads return the addressed array byte.
- R7: Writing 0x70 selects read-status mode. The status byte has bit 7 = 1 when the controller is ready and 0 when it is busy, and bits 6..0 are 0.
- R8: Writing 0x90 selects signature mode. A read with row bit 0 = 0 returns 0x20, and a read with row bit 0 = 1 returns 0x30.
- R9: Writing 0x40 and then any data byte starts a program of the addressed byte. The controller is busy for PROG_CYC clocks, the byte becomes old AND data, and the mode becomes read-status.
- R10: Writing 0x20 and then 0xD0 erases the BLK_BYTES-aligned block around the address to 0xFF. The controller is busy for ERASE_CYC clocks, and the mode becomes read-status. If 0x20 is followed by any other byte, the sequence is cancelled and the mode is unchanged.
- R11: While the controller is busy, every write is ignored, 0xFF included, and reads keep returning the status byte.
- R12: A reset during a program or erase aborts it. The targeted byte, or every byte of the targeted block, is set to POISON (0xA5), and the controller becomes ready.
- R13: A write of any other opcode leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Device reset pin, active low, sampled |
| rc_sel | input | 1 | 0 selects the row half, 1 selects the column half |
| addr_in | input | 11 | Multiplexed address half |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; a rising edge commits a write |
| dq_in | input | 8 | Data written by the host |
| dq_out | output | 8 | Data returned on a read |
| dq_oe | output | 1 | Drive enable for the data pins |

## Verification
A wrong mode register shows up at the very next bus read: the byte returned is an array byte, the status byte or an ID code when a different one was due. A stuck or mis-loaded busy counter shows up in two ways. Status bit 7 stays low too long or clears too early, and a 0xFF written during the operation takes effect when it should be dropped. Broken abort or erase steering is visible only when the affected bytes are read back after returning to read-array mode. The checks therefore pair each operation with a later array read.

// File: rtl/fmx_pkg.sv
package fmx_pkg;
   typedef enum logic [1:0] {M_ARRAY, M_STATUS, M_SIG} fmx_mode_e;
   typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE} fmx_pend_e;
   localparam logic [7:0] OP_READ_ARRAY = 8'hFF;
   localparam logic [7:0] OP_READ_STAT  = 8'h70;
   localparam logic [7:0] OP_READ_SIG   = 8'h90;
   localparam logic [7:0] OP_PROGRAM    = 8'h40;
   localparam logic [7:0] OP_ERASE      = 8'h20;
   localparam logic [7:0] OP_CONFIRM    = 8'hD0;
endpackage

// File: rtl/fmx_addr_latch.sv
module fmx_addr_latch #(
   parameter int ADDR_W = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rc_sel,
   input  logic [ADDR_W-1:0] addr_in,
   output logic [ADDR_W-1:0] row_q,
   output logic [ADDR_W-1:0] col_q,
   output logic              addr_ok
);
   logic row_ok, col_ok;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         row_ok <= 1'b0;
         col_ok <= 1'b0;
         row_q  <= '0;
         col_q  <= '0;
      end else if (!rc_sel) begin
         row_q  <= addr_in;
         row_ok <= 1'b1;
      end else begin
         col_q  <= addr_in;
         col_ok <= 1'b1;
      end
   end

   assign addr_ok = row_ok & col_ok;
endmodule

// File: rtl/fmx_pec.sv
module fmx_pec #(
   parameter int PROG_CYC  = 40,
   parameter int ERASE_CYC = 60,
   parameter int IW        = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_prog,
   input  logic          start_erase,
   input  logic [IW-1:0] idx_in,
   input  logic [7:0]    data_in,
   output logic          busy,
   output logic          done,
   output logic          op_is_erase,
   output logic [IW-1:0] op_idx,
   output logic [7:0]    op_data
);
   localparam int MAXC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CW   = $clog2(MAXC + 1);

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt         <= '0;
         op_is_erase <= 1'b0;
         op_idx      <= '0;
         op_data     <= '0;
      end else if (start_prog || start_erase) begin
         cnt         <= start_erase ? CW'(ERASE_CYC) : CW'(PROG_CYC);
         op_is_erase <= start_erase;
         op_idx      <= idx_in;
         op_data     <= data_in;
      end else if (cnt != '0) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign busy = (cnt != '0);
   assign done = (cnt == CW'(1));

   p_start_sets_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (start_prog || start_erase) |=> busy);
endmodule

// File: rtl/fmx_array.sv
module fmx_array #(
   parameter int          DEPTH     = 64,
   parameter int          BLK_BYTES = 16,
   parameter logic [7:0]  POISON    = 8'hA5,
   localparam int         IW        = $clog2(DEPTH),
   localparam int         BW        = $clog2(BLK_BYTES)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          busy,
   input  logic          done,
   input  logic          op_is_erase,
   input  logic [IW-1:0] op_idx,
   input  logic [7:0]    op_data,
   input  logic [IW-1:0] rd_idx,
   output logic [7:0]    rd_data
);
   logic [7:0] cells [DEPTH];
   wire        abort = !rst_n && busy;

   for (genvar i = 0; i < DEPTH; i++) begin : g_cell
      localparam logic [IW-1:0] ME = IW'(i);
      logic       in_blk;
      logic       is_me;
      logic [7:0] q;

      if (BLK_BYTES == DEPTH) begin : g_whole
         assign in_blk = 1'b1;
      end else begin : g_part
         assign in_blk = (op_idx[IW-1:BW] == ME[IW-1:BW]);
      end
      assign is_me = (op_idx == ME);

      always_ff @(posedge clk) begin
         if (abort) begin
            if (op_is_erase ? in_blk : is_me) q <= POISON;
         end else if (done) begin
            if (op_is_erase && in_blk)      q <= 8'hFF;
            else if (!op_is_erase && is_me) q <= q & op_data;
         end
      end
      assign cells[i] = q;
   end

   assign rd_data = cells[rd_idx];
endmodule

// File: rtl/fmx_cmd_fsm.sv
module fmx_cmd_fsm
   import fmx_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      wr_evt,
   input  logic [7:0] wr_data,
   input  logic      busy,
   output fmx_mode_e mode,
   output logic      start_prog,
   output logic      start_erase
);
   fmx_pend_e pend;
   wire take = wr_evt && !busy;

   assign start_prog  = take && (pend == P_PROG);
   assign start_erase = take && (pend == P_ERASE) && (wr_data == OP_CONFIRM);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode <= M_ARRAY;
         pend <= P_NONE;
      end else if (take) begin
         pend <= P_NONE;
         case (pend)
            P_PROG:  mode <= M_STATUS;
            P_ERASE: if (wr_data == OP_CONFIRM) mode <= M_STATUS;
            default: begin
               case (wr_data)
                  OP_READ_ARRAY: mode <= M_ARRAY;
                  OP_READ_STAT:  mode <= M_STATUS;
                  OP_READ_SIG:   mode <= M_SIG;
                  OP_PROGRAM:    pend <= P_PROG;
                  OP_ERASE:      pend <= P_ERASE;
                  default:       ;
               endcase
            end
         endcase
      end
   end

   p_busy_in_status_r11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (mode == M_STATUS));
   p_reset_to_array_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (mode == M_ARRAY));
endmodule

// File: rtl/fmx_flash_ctl.sv
module fmx_flash_ctl
   import fmx_pkg::*;
#(
   parameter int         ADDR_W    = 11,
   parameter int         DEPTH     = 64,
   parameter int         BLK_BYTES = 16,
   parameter int         PROG_CYC  = 40,
   parameter int         ERASE_CYC = 60,
   parameter logic [7:0] POISON    = 8'hA5,
   parameter logic [7:0] MFR_CODE  = 8'h20,
   parameter logic [7:0] DEV_CODE  = 8'h30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rc_sel,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [7:0]        dq_in,
   output logic [7:0]        dq_out,
   output logic              dq_oe
);
   localparam int IW = $clog2(DEPTH);

   initial begin
      a_depth_pow2: assert (DEPTH == (1 << IW)) else $error("DEPTH must be a power of two");
      a_depth_fit:  assert (IW <= 2 * ADDR_W) else $error("DEPTH exceeds address space");
      a_blk_size:   assert (BLK_BYTES >= 1 && BLK_BYTES <= DEPTH &&
                            BLK_BYTES == (1 << $clog2(BLK_BYTES)))
                       else $error("BLK_BYTES must be a power of two within DEPTH");
      a_cycles:     assert (PROG_CYC >= 2 && ERASE_CYC >= 2) else $error("cycle counts too small");
   end

   logic [ADDR_W-1:0]   row_q, col_q;
   logic                addr_ok;
   logic [2*ADDR_W-1:0] full_addr;
   logic [IW-1:0]       idx;
   logic                we_d, wr_evt;
   logic                busy, done, op_is_erase, start_prog, start_erase;
   logic [IW-1:0]       op_idx;
   logic [7:0]          op_data, arr_byte, rd_byte;
   fmx_mode_e           mode;

   fmx_addr_latch #(.ADDR_W(ADDR_W)) u_addr (
      .clk(clk), .rst_n(rst_n), .rc_sel(rc_sel), .addr_in(addr_in),
      .row_q(row_q), .col_q(col_q), .addr_ok(addr_ok));

   assign full_addr = {col_q, row_q};
   assign idx       = full_addr[IW-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) we_d <= 1'b1;
      else        we_d <= we_n;
   end
   assign wr_evt = rst_n && addr_ok && !we_d && we_n && oe_n;

   fmx_cmd_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .wr_evt(wr_evt), .wr_data(dq_in), .busy(busy),
      .mode(mode), .start_prog(start_prog), .start_erase(start_erase));

   fmx_pec #(.PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .IW(IW)) u_pec (
      .clk(clk), .rst_n(rst_n), .start_prog(start_prog), .start_erase(start_erase),
      .idx_in(idx), .data_in(dq_in), .busy(busy), .done(done),
      .op_is_erase(op_is_erase), .op_idx(op_idx), .op_data(op_data));

   fmx_array #(.DEPTH(DEPTH), .BLK_BYTES(BLK_BYTES), .POISON(POISON)) u_arr (
      .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .op_is_erase(op_is_erase),
      .op_idx(op_idx), .op_data(op_data), .rd_idx(idx), .rd_data(arr_byte));

   always_comb begin
      case (mode)
         M_STATUS: rd_byte = {~busy, 7'b0};
         M_SIG:    rd_byte = row_q[0] ? DEV_CODE : MFR_CODE;
         default:  rd_byte = arr_byte;
      endcase
   end

   assign dq_oe  = rst_n && addr_ok && !oe_n && we_n;
   assign dq_out = rd_byte;

   p_wr_spaced_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_evt |=> !wr_evt);
endmodule

// File: tb/sim_fmx_flash_ctl.sv
module sim_fmx_flash_ctl;
   localparam int CLK_P = 10;
   localparam logic [1:0] K_W = 2'd0, K_R = 2'd1, K_D = 2'd2;
   localparam int NV = 34;
   // fields: kind, row, data, expected, requirement number
   localparam logic [32:0] VT [NV] = '{
      {K_W, 11'd0,  8'h90, 8'h00, 4'd8},   // R8 enter signature mode
      {K_R, 11'd0,  8'h00, 8'h20, 4'd8},   // R8 manufacturer code
      {K_R, 11'd1,  8'h00, 8'h30, 4'd8},   // R8 device code
      {K_W, 11'd0,  8'h20, 8'h00, 4'd10},  // R10 erase setup
      {K_W, 11'd0,  8'hD0, 8'h00, 4'd10},  // R10 confirm
      {K_R, 11'd0,  8'h00, 8'h00, 4'd7},   // R7 busy status
      {K_D, 11'd0,  8'd70, 8'h00, 4'd10},
      {K_R, 11'd0,  8'h00, 8'h80, 4'd7},   // R7 ready status
      {K_W, 11'd0,  8'hFF, 8'h00, 4'd6},   // R6 read array
      {K_R, 11'd3,  8'h00, 8'hFF, 4'd10},  // R10 erased byte
      {K_R, 11'd15, 8'h00, 8'hFF, 4'd10},  // R10 block end erased
      {K_W, 11'd3,  8'h40, 8'h00, 4'd9},   // R9 program setup
      {K_W, 11'd3,  8'h3C, 8'h00, 4'd9},   // R9 program data
      {K_R, 11'd3,  8'h00, 8'h00, 4'd11},  // R11 busy status
      {K_W, 11'd3,  8'hFF, 8'h00, 4'd11},  // R11 read array while busy
      {K_R, 11'd3,  8'h00, 8'h00, 4'd11},  // R11 still status
      {K_D, 11'd0,  8'd70, 8'h00, 4'd9},
      {K_R, 11'd3,  8'h00, 8'h80, 4'd9},   // R9 ready after program
      {K_W, 11'd3,  8'hFF, 8'h00, 4'd6},   // R6
      {K_R, 11'd3,  8'h00, 8'h3C, 4'd9},   // R9 programmed value
      {K_R, 11'd4,  8'h00, 8'hFF, 4'd9},   // R9 neighbour untouched
      {K_W, 11'd3,  8'h40, 8'h00, 4'd9},   // R9 second program
      {K_W, 11'd3,  8'hF0, 8'h00, 4'd9},
      {K_D, 11'd0,  8'd70, 8'h00, 4'd9},
      {K_W, 11'd3,  8'hFF, 8'h00, 4'd6},
      {K_R, 11'd3,  8'h00, 8'h30, 4'd9},   // R9 AND of 3C and F0
      {K_W, 11'd3,  8'h11, 8'h00, 4'd13},  // R13 unknown opcode
      {K_R, 11'd3,  8'h00, 8'h30, 4'd13},  // R13 R3 array unchanged
      {K_W, 11'd3,  8'h70, 8'h00, 4'd7},   // R7 read status
      {K_R, 11'd3,  8'h00, 8'h80, 4'd7},
      {K_W, 11'd3,  8'h20, 8'h00, 4'd10},  // R10 erase setup
      {K_W, 11'd3,  8'h55, 8'h00, 4'd10},  // R10 cancel
      {K_R, 11'd3,  8'h00, 8'h80, 4'd10},  // R10 mode unchanged
      {K_W, 11'd3,  8'hFF, 8'h00, 4'd6}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rc_sel = 1'b1;
   logic [10:0] addr_in = '0;
   logic        oe_n = 1'b1;
   logic        we_n = 1'b1;
   logic [7:0]  dq_in = '0;
   logic [7:0]  dq_out;
   logic        dq_oe;
   int          n_chk = 0;
   int          n_err = 0;

   fmx_flash_ctl u0 (
      .clk(clk), .rst_n(rst_n), .rc_sel(rc_sel), .addr_in(addr_in), .oe_n(oe_n),
      .we_n(we_n), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe));

   always #(CLK_P/2) clk = ~clk;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int r, input string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL R%0d %s: actual %h expected %h", r, what, act, exp);
      end
   endtask

   task automatic set_addr(input logic [10:0] row, input logic [10:0] col);
      @(negedge clk); rc_sel = 1'b0; addr_in = row;
      @(negedge clk); rc_sel = 1'b1; addr_in = col;
   endtask

   task automatic bus_wr(input logic [10:0] row, input logic [7:0] d);
      set_addr(row, 11'd0);
      @(negedge clk); dq_in = d; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic bus_rd(input logic [10:0] row, input logic [7:0] exp, input int r, input string what);
      set_addr(row, 11'd0);
      @(negedge clk); oe_n = 1'b0;
      @(negedge clk);
      chk(dq_oe ? dq_out : 8'hzz, exp, r, what);
      oe_n = 1'b1;
   endtask

   task automatic pulse_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk);
      @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * 100000);
      n_err++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      // R5 outputs off during reset
      repeat (2) @(negedge clk);
      oe_n = 1'b0;
      @(negedge clk);
      chk({7'b0, dq_oe}, 8'h00, 5, "dq_oe during reset");
      oe_n = 1'b1;
      rst_n = 1'b1;
      // R1 only the column half loaded: no drive
      repeat (2) @(negedge clk);
      oe_n = 1'b0;
      @(negedge clk);
      chk({7'b0, dq_oe}, 8'h00, 1, "read before row half");
      oe_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         case (VT[i][32:31])
            K_W: bus_wr(VT[i][30:20], VT[i][19:12]);
            K_R: bus_rd(VT[i][30:20], VT[i][11:4], int'(VT[i][3:0]), $sformatf("vector %0d", i));
            default: repeat (int'(VT[i][19:12])) @(negedge clk);
         endcase
      end

      // R4 output disable
      set_addr(11'd2, 11'd0);
      @(negedge clk);
      chk({7'b0, dq_oe}, 8'h00, 4, "oe_n high");
      // R2 no drive while we_n low
      oe_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      chk({7'b0, dq_oe}, 8'h00, 2, "oe_n low with we_n low");
      // R3 write ending while oe_n low is dropped
      dq_in = 8'h90;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); oe_n = 1'b1;
      @(negedge clk);
      bus_rd(11'd2, 8'hFF, 3, "write with oe_n low ignored");
      // R5 reset returns to read-array mode
      bus_wr(11'd2, 8'h90);
      bus_rd(11'd2, 8'h20, 8, "signature before reset");
      pulse_reset();
      bus_rd(11'd2, 8'hFF, 5, "array mode after reset");
      // R12 reset during a program aborts it
      bus_wr(11'd5, 8'h40);
      bus_wr(11'd5, 8'h0F);
      pulse_reset();
      bus_rd(11'd5, 8'hA5, 12, "poisoned target");
      bus_rd(11'd6, 8'hFF, 12, "neighbour of aborted program");
      bus_wr(11'd5, 8'h70);
      bus_rd(11'd5, 8'h80, 12, "ready after abort");

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule